// File: doc/BRIEF.md
# Software Flow Control Engine for a Serial Channel

This block sits between one serial channel's receiver, its receive FIFO and its transmitter, and carries out in-band XON/XOFF flow control. It watches every decoded received character for the two flow codes, gates the local transmitter when the far end asks it to stop, and asks the far end to stop or resume by inserting flow characters into the outgoing stream as the local receive FIFO fills and drains. Host software can also request a flow character, but only while no automatic action is enabled.

Received flow characters can be removed from the receive path or passed through like ordinary data. Each one sets a sticky status bit, and a maskable interrupt is raised from those bits. A status read clears them. Framing, baud timing and FIFO storage belong to the neighbouring blocks. The fill level comes in as a count, and the transmitter offers a one-cycle load slot at each character boundary.

Top module: `xon_xoff_flow`

## Requirements
- R1: After reset the transmitter is not gated, no flow character is pending, both status bits are 0 and `flowIrq` is 0.
- R2: When `modeSel[0]` is 1, a received character equal to `xoffCode` gates data, so `txDataTake` stays 0. A received `xonCode` ungates it. The gate reads 0 one cycle after `modeSel[0]` is 0.
- R3: When `modeSel[1]` is 1, no flow character is pending and no XOFF is outstanding, a fill level of HIGH_MARK (12) or more queues an XOFF. The XOFF is then outstanding.
- R4: With an XOFF outstanding under R3, a fill level of LOW_MARK (8) or less queues an XON. A level above LOW_MARK queues nothing.
- R5: With `modeSel` = 00, a pulse on `hostSendXoff` or `hostSendXon` queues that character, and XOFF wins if both pulse together. With any other mode the pulses are ignored.
- R6: A queued flow character is loaded at the next cycle with `txReady` high, ahead of any data and even while gated. In that cycle `txDataTake` is 0 and `txChar` carries the code.
- R7: With `stripFlow` = 1, a received flow character is not pushed (`rxPushValid` = 0). With `stripFlow` = 0, it is pushed like data. Other characters are always pushed.
- R8: In every mode, a received XON or XOFF sets `seenXon` or `seenXoff`. `statusRead` clears them, and a new arrival wins in the same cycle. `flowIrq` = `irqEnable` and (`seenXon` or `seenXoff`).
- R9: Flow codes are recognised from the current `xonCode`/`xoffCode` inputs. A byte that equals neither code is treated as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Bit 0 = automatic transmit gating, bit 1 = automatic receive-side flow |
| stripFlow | input | 1 | 1 = discard received flow characters |
| xonCode | input | 8 | Resume character code |
| xoffCode | input | 8 | Stop character code |
| rxValid | input | 1 | Decoded received character valid |
| rxChar | input | 8 | Decoded received character |
| rxPushValid | output | 1 | Push strobe to receive FIFO |
| rxPushChar | output | 8 | Character pushed to receive FIFO |
| rxLevel | input | LVL_W | Receive FIFO fill level |
| hostSendXon | input | 1 | Host request to send XON |
| hostSendXoff | input | 1 | Host request to send XOFF |
| txReady | input | 1 | Transmitter at character boundary, accepts a load |
| txDataValid | input | 1 | Transmit FIFO has a data character |
| txDataChar | input | 8 | Head of transmit FIFO |
| txLoad | output | 1 | Character loaded into transmitter |
| txChar | output | 8 | Character loaded |
| txDataTake | output | 1 | Pop transmit FIFO |
| txGated | output | 1 | Transmit data halted by far end |
| irqEnable | input | 1 | Interrupt mask bit |
| statusRead | input | 1 | Read of flow status, clears it |
| seenXon | output | 1 | Sticky: XON received |
| seenXoff | output | 1 | Sticky: XOFF received |
| flowIrq | output | 1 | Flow character interrupt |

## Verification
The bench builds the block with its default parameters: a 5-bit fill level, HIGH_MARK 12 and LOW_MARK 8. With these values it can sweep the fill level through both hysteresis thresholds, and one step on either side of each, in a handful of cycles. A behavioural model tracks the gate, the outstanding XOFF, the pending queue and the status bits, and it is compared with the outputs on every cycle. The stimulus is a directed walk through each mode, followed by a pseudo-random phase that mixes mode changes, host pulses and flow codes.

// File: rtl/flowPkg.sv
package flowPkg;
  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_XON  = 2'd1,
    PEND_XOFF = 2'd2
  } pendKind_t;

  typedef struct packed {
    logic sendFlow;
    logic flowIsXoff;
    logic dataAllowed;
  } ctrlStrobe_t;
endpackage

// File: rtl/flow_ctrl_control.sv
module flow_ctrl_control
  import flowPkg::*;
#(
  parameter int LVL_W     = 5,
  parameter int HIGH_MARK = 12,
  parameter int LOW_MARK  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic             hostSendXon,
  input  logic             hostSendXoff,
  input  logic             gotXon,
  input  logic             gotXoff,
  input  logic             flowTaken,
  input  logic             statusRead,
  input  logic             irqEnable,
  output ctrlStrobe_t      ctrl,
  output logic             txGated,
  output logic             seenXon,
  output logic             seenXoff,
  output logic             flowIrq
);
  localparam logic [LVL_W-1:0] HIGH_LVL = LVL_W'(HIGH_MARK);
  localparam logic [LVL_W-1:0] LOW_LVL  = LVL_W'(LOW_MARK);

  pendKind_t pend, pendNext;
  logic stopped, stoppedNext;
  logic halted, haltedNext;
  logic hostMode, autoTx, autoRx;

  assign hostMode = (modeSel == 2'b00);
  assign autoTx   = modeSel[0];
  assign autoRx   = modeSel[1];

  always_comb begin
    pendNext    = pend;
    stoppedNext = stopped;
    if (flowTaken) pendNext = PEND_NONE;
    if (hostMode) begin
      if (hostSendXoff)     pendNext = PEND_XOFF;
      else if (hostSendXon) pendNext = PEND_XON;
    end
    if (autoRx && pend == PEND_NONE) begin
      if (!stopped && rxLevel >= HIGH_LVL) begin
        pendNext    = PEND_XOFF;
        stoppedNext = 1'b1;
      end else if (stopped && rxLevel <= LOW_LVL) begin
        pendNext    = PEND_XON;
        stoppedNext = 1'b0;
      end
    end
  end

  always_comb begin
    haltedNext = halted;
    if (!autoTx)      haltedNext = 1'b0;
    else if (gotXoff) haltedNext = 1'b1;
    else if (gotXon)  haltedNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend     <= PEND_NONE;
      stopped  <= 1'b0;
      halted   <= 1'b0;
      seenXon  <= 1'b0;
      seenXoff <= 1'b0;
    end else begin
      pend     <= pendNext;
      stopped  <= stoppedNext;
      halted   <= haltedNext;
      seenXon  <= gotXon  | (seenXon  & ~statusRead);
      seenXoff <= gotXoff | (seenXoff & ~statusRead);
    end
  end

  always_comb begin
    ctrl.sendFlow    = (pend != PEND_NONE);
    ctrl.flowIsXoff  = (pend == PEND_XOFF);
    ctrl.dataAllowed = ~halted;
  end

  assign txGated = halted;
  assign flowIrq = irqEnable & (seenXon | seenXoff);

  assert_gate_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    !modeSel[0] |=> !txGated);

  assert_status_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !gotXon && !gotXoff) |=> (!seenXon && !seenXoff));

  assert_auto_xoff_R3: assert property (@(posedge clk) disable iff (!rstN)
    (autoRx && !stopped && pend == PEND_NONE && rxLevel >= HIGH_LVL)
      |=> (pend == PEND_XOFF && stopped));

  assert_pend_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pend != PEND_NONE && !flowTaken && !hostMode) |=> (pend == $past(pend)));
endmodule

// File: rtl/flow_ctrl_datapath.sv
module flow_ctrl_datapath
  import flowPkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stripFlow,
  input  logic [CHAR_W-1:0] xonCode,
  input  logic [CHAR_W-1:0] xoffCode,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxChar,
  input  logic              txReady,
  input  logic              txDataValid,
  input  logic [CHAR_W-1:0] txDataChar,
  input  ctrlStrobe_t       ctrl,
  output logic              gotXon,
  output logic              gotXoff,
  output logic              rxPushValid,
  output logic [CHAR_W-1:0] rxPushChar,
  output logic              txLoad,
  output logic [CHAR_W-1:0] txChar,
  output logic              txDataTake,
  output logic              flowTaken
);
  logic isFlow;
  logic [CHAR_W-1:0] flowCode;

  assign gotXon      = rxValid && (rxChar == xonCode);
  assign gotXoff     = rxValid && (rxChar == xoffCode);
  assign isFlow      = gotXon | gotXoff;
  assign rxPushValid = rxValid & ~(stripFlow & isFlow);
  assign rxPushChar  = rxChar;

  assign flowCode   = ctrl.flowIsXoff ? xoffCode : xonCode;
  assign flowTaken  = txReady & ctrl.sendFlow;
  assign txDataTake = txReady & ~ctrl.sendFlow & txDataValid & ctrl.dataAllowed;
  assign txLoad     = flowTaken | txDataTake;
  assign txChar     = ctrl.sendFlow ? flowCode : txDataChar;

  assert_no_data_when_gated_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.dataAllowed |-> !txDataTake);

  assert_strip_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stripFlow && rxValid && (rxChar == xonCode || rxChar == xoffCode)) |-> !rxPushValid);

  assert_flow_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.sendFlow && txReady) |-> (txLoad && !txDataTake));
endmodule

// File: rtl/xon_xoff_flow.sv
module xon_xoff_flow
  import flowPkg::*;
#(
  parameter int CHAR_W    = 8,
  parameter int LVL_W     = 5,
  parameter int HIGH_MARK = 12,
  parameter int LOW_MARK  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              stripFlow,
  input  logic [CHAR_W-1:0] xonCode,
  input  logic [CHAR_W-1:0] xoffCode,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxChar,
  output logic              rxPushValid,
  output logic [CHAR_W-1:0] rxPushChar,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic              hostSendXon,
  input  logic              hostSendXoff,
  input  logic              txReady,
  input  logic              txDataValid,
  input  logic [CHAR_W-1:0] txDataChar,
  output logic              txLoad,
  output logic [CHAR_W-1:0] txChar,
  output logic              txDataTake,
  output logic              txGated,
  input  logic              irqEnable,
  input  logic              statusRead,
  output logic              seenXon,
  output logic              seenXoff,
  output logic              flowIrq
);
  ctrlStrobe_t ctrl;
  logic gotXon, gotXoff, flowTaken;

  flow_ctrl_control #(.LVL_W(LVL_W), .HIGH_MARK(HIGH_MARK), .LOW_MARK(LOW_MARK)) uCtrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .rxLevel(rxLevel),
    .hostSendXon(hostSendXon), .hostSendXoff(hostSendXoff),
    .gotXon(gotXon), .gotXoff(gotXoff), .flowTaken(flowTaken),
    .statusRead(statusRead), .irqEnable(irqEnable), .ctrl(ctrl),
    .txGated(txGated), .seenXon(seenXon), .seenXoff(seenXoff), .flowIrq(flowIrq)
  );

  flow_ctrl_datapath #(.CHAR_W(CHAR_W)) uData (
    .clk(clk), .rstN(rstN), .stripFlow(stripFlow), .xonCode(xonCode), .xoffCode(xoffCode),
    .rxValid(rxValid), .rxChar(rxChar), .txReady(txReady), .txDataValid(txDataValid),
    .txDataChar(txDataChar), .ctrl(ctrl), .gotXon(gotXon), .gotXoff(gotXoff),
    .rxPushValid(rxPushValid), .rxPushChar(rxPushChar), .txLoad(txLoad), .txChar(txChar),
    .txDataTake(txDataTake), .flowTaken(flowTaken)
  );
endmodule

// File: tb/xon_xoff_flow_test.sv
module xon_xoff_flow_test;
  localparam int LW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic stripFlow = 1'b0;
  logic [7:0] xonCode = 8'h11, xoffCode = 8'h13;
  logic rxValid = 1'b0;
  logic [7:0] rxChar = 8'h00;
  logic rxPushValid;
  logic [7:0] rxPushChar;
  logic [LW-1:0] rxLevel = '0;
  logic hostSendXon = 1'b0, hostSendXoff = 1'b0;
  logic txReady = 1'b0, txDataValid = 1'b0;
  logic [7:0] txDataChar = 8'hA5;
  logic txLoad, txDataTake, txGated, seenXon, seenXoff, flowIrq;
  logic [7:0] txChar;
  logic irqEnable = 1'b0, statusRead = 1'b0;

  int total = 0;
  int bad = 0;
  bit checking = 0;
  bit finished = 0;

  // behavioural reference state
  int mPend = 0;           // 0 none, 1 xon, 2 xoff
  bit mStopped = 0, mHalted = 0, mSeenOn = 0, mSeenOff = 0;

  always #2 clk = ~clk;

  xon_xoff_flow uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .stripFlow(stripFlow),
    .xonCode(xonCode), .xoffCode(xoffCode), .rxValid(rxValid), .rxChar(rxChar),
    .rxPushValid(rxPushValid), .rxPushChar(rxPushChar), .rxLevel(rxLevel),
    .hostSendXon(hostSendXon), .hostSendXoff(hostSendXoff), .txReady(txReady),
    .txDataValid(txDataValid), .txDataChar(txDataChar), .txLoad(txLoad),
    .txChar(txChar), .txDataTake(txDataTake), .txGated(txGated),
    .irqEnable(irqEnable), .statusRead(statusRead), .seenXon(seenXon),
    .seenXoff(seenXoff), .flowIrq(flowIrq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    bit isOn, isOff, taken;
    int np;
    if (!rstN) begin
      mPend = 0; mStopped = 0; mHalted = 0; mSeenOn = 0; mSeenOff = 0;
    end else begin
      isOn  = rxValid && rxChar == xonCode;
      isOff = rxValid && rxChar == xoffCode;
      taken = txReady && mPend != 0;
      np = taken ? 0 : mPend;
      if (modeSel == 2'b00) begin
        if (hostSendXoff) np = 2;
        else if (hostSendXon) np = 1;
      end
      if (modeSel[1] && mPend == 0) begin
        if (!mStopped && rxLevel >= 12) begin np = 2; mStopped = 1; end
        else if (mStopped && rxLevel <= 8) begin np = 1; mStopped = 0; end
      end
      mPend = np;
      if (!modeSel[0]) mHalted = 0;
      else if (isOff) mHalted = 1;
      else if (isOn) mHalted = 0;
      mSeenOn  = isOn  | (mSeenOn  & ~statusRead);
      mSeenOff = isOff | (mSeenOff & ~statusRead);
    end
  end

  always @(negedge clk) begin
    bit isOn, isOff, expLoad, expTake, expPush;
    logic [7:0] expChar;
    if (checking) begin
      isOn  = rxValid && rxChar == xonCode;
      isOff = rxValid && rxChar == xoffCode;
      expTake = txReady && mPend == 0 && txDataValid && !mHalted;
      expLoad = (txReady && mPend != 0) || expTake;
      expChar = (mPend == 2) ? xoffCode : (mPend == 1) ? xonCode : txDataChar;
      expPush = rxValid && !(stripFlow && (isOn || isOff));
      chk("R6 model txLoad", txLoad, expLoad);
      if (expLoad) chk("R6 model txChar", txChar, expChar);
      chk("R2 model txDataTake", txDataTake, expTake);
      chk("R2 model txGated", txGated, mHalted);
      chk("R7 model rxPushValid", rxPushValid, expPush);
      if (expPush) chk("R7 model rxPushChar", rxPushChar, rxChar);
      chk("R8 model seenXon", seenXon, mSeenOn);
      chk("R8 model seenXoff", seenXoff, mSeenOff);
      chk("R8 model flowIrq", flowIrq, irqEnable && (mSeenOn || mSeenOff));
    end
  end

  initial begin
    int seed;
    repeat (3) tick();
    rstN = 1'b1;
    checking = 1;
    @(negedge clk);
    chk("R1 gate", txGated, 0);
    chk("R1 irq", flowIrq, 0);
    chk("R1 seenXon", seenXon, 0);
    chk("R1 seenXoff", seenXoff, 0);
    txReady = 1'b1;
    #1 chk("R1 no pending", txLoad, 0);

    // R2 automatic transmit gating
    tick(); modeSel = 2'b01; txDataValid = 1'b1;
    @(negedge clk); chk("R2 data flows", txDataTake, 1);
    tick(); rxValid = 1'b1; rxChar = 8'h13;
    tick(); rxValid = 1'b0;
    @(negedge clk); chk("R2 gated", txGated, 1); chk("R2 no take", txDataTake, 0);
    tick(); rxValid = 1'b1; rxChar = 8'h11;
    tick(); rxValid = 1'b0;
    @(negedge clk); chk("R2 resumed", txDataTake, 1);
    tick(); rxValid = 1'b1; rxChar = 8'h13;
    tick(); rxValid = 1'b0; modeSel = 2'b00;
    tick();
    @(negedge clk); chk("R2 gate off when mode clear", txGated, 0);

    // R7 strip
    tick(); stripFlow = 1'b1; rxValid = 1'b1; rxChar = 8'h11;
    @(negedge clk); chk("R7 xon stripped", rxPushValid, 0);
    tick(); rxChar = 8'h42;
    @(negedge clk); chk("R7 data kept", rxPushValid, 1);
    tick(); stripFlow = 1'b0; rxChar = 8'h13;
    @(negedge clk); chk("R7 xoff passed", rxPushValid, 1);

    // R8 status and interrupt
    tick(); rxValid = 1'b0; statusRead = 1'b1;
    tick(); statusRead = 1'b0;
    @(negedge clk); chk("R8 cleared on", seenXon, 0); chk("R8 cleared off", seenXoff, 0);
    tick(); rxValid = 1'b1; rxChar = 8'h13;
    tick(); rxValid = 1'b0;
    @(negedge clk); chk("R8 sticky off", seenXoff, 1); chk("R8 masked", flowIrq, 0);
    tick(); irqEnable = 1'b1;
    @(negedge clk); chk("R8 irq", flowIrq, 1);

    // R5 host commands
    tick(); txReady = 1'b0; hostSendXon = 1'b1;
    tick(); hostSendXon = 1'b0; txReady = 1'b1;
    @(negedge clk); chk("R5 host xon load", txLoad, 1); chk("R6 xon code", txChar, 8'h11);
    chk("R6 data held", txDataTake, 0);
    tick(); modeSel = 2'b11; hostSendXoff = 1'b1; rxLevel = 5'd3;
    tick(); hostSendXoff = 1'b0;
    @(negedge clk); chk("R5 host locked out", txChar, 8'hA5); chk("R5 data taken", txDataTake, 1);

    // R3 / R4 receive-side hysteresis
    tick(); modeSel = 2'b10; rxLevel = 5'd11;
    tick();
    @(negedge clk); chk("R3 below mark", txChar, 8'hA5);
    tick(); rxLevel = 5'd12;
    tick();
    @(negedge clk); chk("R3 xoff sent", txChar, 8'h13);
    tick(); rxLevel = 5'd9;
    tick();
    @(negedge clk); chk("R4 no xon above mark", txChar, 8'hA5);
    tick(); rxLevel = 5'd8;
    tick();
    @(negedge clk); chk("R4 xon sent", txChar, 8'h11);

    // R6 flow character while gated
    tick(); modeSel = 2'b11; txReady = 1'b0; rxLevel = 5'd3; rxValid = 1'b1; rxChar = 8'h13;
    tick(); rxValid = 1'b0; rxLevel = 5'd13;
    tick(); txReady = 1'b1;
    @(negedge clk); chk("R6 gated", txGated, 1); chk("R6 xoff while gated", txChar, 8'h13);
    chk("R6 load while gated", txLoad, 1);
    tick();
    @(negedge clk); chk("R6 no data after", txLoad, 0);

    // R9 programmable codes
    tick(); xonCode = 8'h55; modeSel = 2'b01; rxValid = 1'b1; rxChar = 8'h55;
    tick(); rxValid = 1'b0;
    @(negedge clk); chk("R9 new xon code", txGated, 0);
    tick(); stripFlow = 1'b1; rxValid = 1'b1; rxChar = 8'h11;
    @(negedge clk); chk("R9 old code is data", rxPushValid, 1);

    // pseudo-random phase against the model
    seed = 7;
    for (int i = 0; i < 400; i++) begin
      tick();
      seed = seed * 1103515245 + 12345;
      modeSel = (i % 50 < 5) ? 2'(seed >>> 3) : modeSel;
      rxValid = seed[16];
      rxChar = seed[17] ? (seed[18] ? xonCode : xoffCode) : 8'(seed >>> 20);
      rxLevel = LW'(seed >>> 9) % 5'd16;
      hostSendXon = seed[24]; hostSendXoff = seed[25] & seed[26];
      txReady = seed[27]; txDataValid = seed[28]; txDataChar = 8'(seed >>> 5);
      stripFlow = seed[29]; statusRead = seed[30] & seed[14]; irqEnable = seed[13];
    end
    tick();
    checking = 0;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule